// File: doc/BRIEF.md
# Instruction Prefetch Buffer with Flush Control

This block sits between the memory port and the execution core of a script-driven DMA engine. It fetches 32-bit instruction words from consecutive byte addresses, four bytes apart, ahead of execution. It holds up to eight of them and hands them to the core in address order over a valid/ready port. Each word leaves with the address it was fetched from.

Some architectural events make the buffered words useless:
- a store that may have rewritten code,
- a write to the script pointer,
- a control transfer whose condition holds,
- a software flush request.

On any of these the buffer is emptied and fetching restarts from a new address. A generation tag travels with every memory request. Responses that come back after a flush with a stale tag are thrown away, so old words never reach the core.

The software flush request is bit 6 of an 8-bit control register. The bit clears itself. Restart addresses follow a fixed priority: a pointer write first, then a taken transfer, then the address of the next undelivered word.

Top module: `instr_prefetch_buf`

## Requirements
- R1: While reset is held, `instValid` is 0 and `ctrlRdData` is 0. The first memory request after reset asks for address `RESET_ADDR`.
- R2: Delivered words come out in increasing address order, in steps of 4. `instAddr` is the fetch address of the word on `instData`.
- R3: Buffered words plus live outstanding requests never exceed `DEPTH` (8). With the core stalled, exactly 8 requests are issued. One more request follows a single consumed word.
- R4: When `storeExec` is 1 and `storeNoFlush` is 0, the buffer is flushed. Fetching restarts at the address of the next undelivered word.
- R5: When `storeExec` and `storeNoFlush` are both 1, there is no effect: the buffer, `instAddr` and the request count are unchanged.
- R6: When `ptrWrite` is 1, the buffer is flushed and the next request goes to `ptrData`.
- R7: When `xferExec` and `xferCondMet` are both 1, the buffer is flushed and fetching restarts at `xferTarget`. When `xferExec` is 1 and `xferCondMet` is 0, there is no effect.
- R8: A write to the control register with bit 6 set flushes the buffer at the next clock edge. Bit 6 reads back as 1 for one cycle after the write and then as 0. The other bits keep what was written. A write with bit 6 clear does not flush.
- R9: Responses whose tag differs from the current generation never enter the buffer.
- R10: A flush has priority over a read of the output in the same cycle. `instValid` is 0 in the cycle after any flush.
- R11: When several flush events occur in the same cycle, the restart address is taken from the pointer write first, then from the taken transfer, then from the next undelivered address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| storeExec | input | 1 | A store instruction executed this cycle |
| storeNoFlush | input | 1 | The store carries the no-flush qualifier |
| ptrWrite | input | 1 | Write to the script pointer |
| ptrData | input | 32 | New script pointer value |
| xferExec | input | 1 | A control-transfer instruction executed |
| xferCondMet | input | 1 | The transfer condition holds |
| xferTarget | input | 32 | Transfer target address |
| ctrlWrite | input | 1 | Write strobe for the control register |
| ctrlWData | input | 8 | Control register write data; bit 6 requests a flush |
| ctrlRdData | output | 8 | Control register readback |
| memReqValid | output | 1 | Memory read request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | 32 | Request byte address |
| memReqTag | output | 2 | Generation tag sent with the request |
| memRspValid | input | 1 | Response valid |
| memRspTag | input | 2 | Tag returned with the response |
| memRspData | input | 32 | Response instruction word |
| instValid | output | 1 | A buffered word is available |
| instReady | input | 1 | The core takes the word |
| instAddr | output | 32 | Address of the presented word |
| instData | output | 32 | Presented instruction word |

## Verification
The bench builds the block with its defaults: `DEPTH` 8, a 2-bit tag, 32-bit words and `RESET_ADDR` of 0x1000. A memory model answers with a six-cycle latency. That latency is longer than the gap between two back-to-back pointer writes, so stale-tag responses really arrive after a flush. The eight-entry depth also lets the stalled-core case fill the buffer within a few dozen cycles. Both the full-buffer credit limit and the no-effect events can then be checked against a frozen output.

// File: rtl/ipb_pkg.sv
package ipb_pkg;
  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic flush;  // discard all buffered words
    logic push;   // store the current memory response
    logic pop;    // the core consumes the head word
  } ipbStrobes_t;
endpackage

// File: rtl/ipb_ctrl.sv
module ipb_ctrl
  import ipb_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                DEPTH      = 8,
  parameter int                TAG_W      = 2,
  parameter int                CTRL_W     = 8,
  parameter int                FLUSH_POS  = 6,
  parameter int                WORD_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  localparam int               CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              storeExec,
  input  logic              storeNoFlush,
  input  logic              ptrWrite,
  input  logic [ADDR_W-1:0] ptrData,
  input  logic              xferExec,
  input  logic              xferCondMet,
  input  logic [ADDR_W-1:0] xferTarget,
  input  logic              ctrlWrite,
  input  logic [CTRL_W-1:0] ctrlWData,
  output logic [CTRL_W-1:0] ctrlRdData,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [TAG_W-1:0]  memReqTag,
  input  logic              memRspValid,
  input  logic [TAG_W-1:0]  memRspTag,
  input  logic              instValid,
  input  logic              instReady,
  input  logic [CNT_W-1:0]  bufCount,
  output logic [ADDR_W-1:0] execAddr,
  output ipbStrobes_t       strobes
);
  localparam logic [CNT_W:0]    LIMIT = (CNT_W + 1)'(DEPTH);
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(WORD_BYTES);

  logic [CTRL_W-1:0] ctrlQ;
  logic [TAG_W-1:0]  genQ;
  logic [CNT_W-1:0]  liveQ;
  logic [ADDR_W-1:0] fetchQ, execQ, restartAddr;
  logic [CNT_W:0]    usedSlots;
  logic storeFlush, xferFlush, flushNow, reqFire, rspLive;

  always_comb begin
    storeFlush  = storeExec & ~storeNoFlush;
    xferFlush   = xferExec & xferCondMet;
    flushNow    = ptrWrite | xferFlush | storeFlush | ctrlQ[FLUSH_POS];
    if (ptrWrite)       restartAddr = ptrData;
    else if (xferFlush) restartAddr = xferTarget;
    else                restartAddr = execQ;
    usedSlots   = {1'b0, bufCount} + {1'b0, liveQ};
    memReqValid = ~flushNow & (usedSlots < LIMIT);
    reqFire     = memReqValid & memReqReady;
    rspLive     = memRspValid & (memRspTag == genQ);
    strobes.flush = flushNow;
    strobes.push  = rspLive & ~flushNow;
    strobes.pop   = instValid & instReady & ~flushNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ  <= '0;
      genQ   <= '0;
      liveQ  <= '0;
      fetchQ <= RESET_ADDR;
      execQ  <= RESET_ADDR;
    end else begin
      if (ctrlWrite) ctrlQ <= ctrlWData;
      else           ctrlQ[FLUSH_POS] <= 1'b0;
      if (flushNow) begin
        genQ   <= genQ + TAG_W'(1);
        liveQ  <= '0;
        fetchQ <= restartAddr;
        execQ  <= restartAddr;
      end else begin
        liveQ <= liveQ + CNT_W'(reqFire) - CNT_W'(rspLive);
        if (reqFire)     fetchQ <= fetchQ + STEP;
        if (strobes.pop) execQ  <= execQ + STEP;
      end
    end
  end

  assign ctrlRdData = ctrlQ;
  assign memReqAddr = fetchQ;
  assign memReqTag  = genQ;
  assign execAddr   = execQ;

  // R3: credit accounting never promises more slots than exist
  p_credit_r3: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, bufCount} + {1'b0, liveQ}) <= LIMIT);
  // R8: flush request bit clears itself unless rewritten
  p_selfclear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[FLUSH_POS] && !(ctrlWrite && ctrlWData[FLUSH_POS])) |=> !ctrlQ[FLUSH_POS]);
  // R6, R11: pointer write wins and sets the next fetch address
  p_ptr_restart_r6: assert property (@(posedge clk) disable iff (!rstN)
    ptrWrite |=> (memReqAddr == $past(ptrData)));
  // R5: a qualified store alone leaves the generation untouched
  p_noflush_store_r5: assert property (@(posedge clk) disable iff (!rstN)
    (storeExec && storeNoFlush && !ptrWrite && !xferFlush && !ctrlQ[FLUSH_POS]) |=> $stable(genQ));
endmodule

// File: rtl/ipb_data.sv
module ipb_data
  import ipb_pkg::*;
#(
  parameter int  DATA_W = 32,
  parameter int  DEPTH  = 8,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ipbStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  count
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DEPTH-1:0][DATA_W-1:0] slotQ;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] countQ;

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (strobes.push && wrPtr == PTR_W'(i)) slotQ[i] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.flush) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      countQ <= '0;
    end else begin
      if (strobes.push) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + PTR_W'(1);
      if (strobes.pop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + PTR_W'(1);
      countQ <= countQ + CNT_W'(strobes.push) - CNT_W'(strobes.pop);
    end
  end

  assign rdData = slotQ[rdPtr];
  assign count  = countQ;

  // R3: occupancy bounded by depth
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= CNT_W'(DEPTH));
  // R3: no write into a full buffer that is not draining
  p_full_no_push_r3: assert property (@(posedge clk) disable iff (!rstN)
    (countQ == CNT_W'(DEPTH) && !strobes.pop) |-> !strobes.push);
  // R10: a flush leaves the buffer empty
  p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flush |=> (countQ == '0));
endmodule

// File: rtl/instr_prefetch_buf.sv
module instr_prefetch_buf
  import ipb_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                DATA_W     = 32,
  parameter int                DEPTH      = 8,
  parameter int                TAG_W      = 2,
  parameter int                CTRL_W     = 8,
  parameter int                FLUSH_POS  = 6,
  parameter logic [ADDR_W-1:0] RESET_ADDR = ADDR_W'(32'h1000)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              storeExec,
  input  logic              storeNoFlush,
  input  logic              ptrWrite,
  input  logic [ADDR_W-1:0] ptrData,
  input  logic              xferExec,
  input  logic              xferCondMet,
  input  logic [ADDR_W-1:0] xferTarget,
  input  logic              ctrlWrite,
  input  logic [CTRL_W-1:0] ctrlWData,
  output logic [CTRL_W-1:0] ctrlRdData,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [TAG_W-1:0]  memReqTag,
  input  logic              memRspValid,
  input  logic [TAG_W-1:0]  memRspTag,
  input  logic [DATA_W-1:0] memRspData,
  output logic              instValid,
  input  logic              instReady,
  output logic [ADDR_W-1:0] instAddr,
  output logic [DATA_W-1:0] instData
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  ipbStrobes_t      strobes;
  logic [CNT_W-1:0] bufCount;

  assign instValid = (bufCount != '0);

  ipb_ctrl #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .TAG_W(TAG_W), .CTRL_W(CTRL_W),
    .FLUSH_POS(FLUSH_POS), .WORD_BYTES(DATA_W / 8), .RESET_ADDR(RESET_ADDR)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .storeExec(storeExec), .storeNoFlush(storeNoFlush),
    .ptrWrite(ptrWrite), .ptrData(ptrData),
    .xferExec(xferExec), .xferCondMet(xferCondMet), .xferTarget(xferTarget),
    .ctrlWrite(ctrlWrite), .ctrlWData(ctrlWData), .ctrlRdData(ctrlRdData),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memReqTag(memReqTag),
    .memRspValid(memRspValid), .memRspTag(memRspTag),
    .instValid(instValid), .instReady(instReady),
    .bufCount(bufCount), .execAddr(instAddr), .strobes(strobes)
  );

  ipb_data #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .wrData(memRspData), .rdData(instData), .count(bufCount)
  );

  // R9: a stale-tagged response cannot raise occupancy
  p_stale_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memRspValid && memRspTag != memReqTag) |=> (bufCount <= $past(bufCount)));
endmodule

// File: tb/sim_instr_prefetch_buf.sv
module sim_instr_prefetch_buf;
  localparam logic [31:0] RST_A = 32'h1000;
  localparam int LAT = 6;

  logic clk = 0, rstN = 0;
  logic storeExec = 0, storeNoFlush = 0, ptrWrite = 0, xferExec = 0, xferCondMet = 0;
  logic ctrlWrite = 0, memReqReady = 1, memRspValid = 0, instReady = 0;
  logic [31:0] ptrData = 0, xferTarget = 0, memRspData = 0;
  logic [7:0]  ctrlWData = 0, ctrlRdData;
  logic [1:0]  memRspTag = 0, memReqTag;
  logic memReqValid, instValid;
  logic [31:0] memReqAddr, instAddr, instData;

  always #4 clk = ~clk;  // 125 MHz

  instr_prefetch_buf u0 (.*);

  int vectors = 0, miscompares = 0, reqCount = 0, cyc = 0;
  bit flushing = 0, sawFirst = 0;
  logic [31:0] firstReq = 0;
  logic [31:0] expQ[$];
  logic [31:0] pAddr[$], pDue[$];
  logic [1:0]  pTag[$];

  function automatic logic [31:0] dataOf(logic [31:0] a);
    return a ^ 32'h5A5A_C3C3;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pushRun(logic [31:0] start);
    expQ.delete();
    for (int i = 0; i < 64; i++) expQ.push_back(start + 32'(4 * i));
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // memory model: drive responses at negedge
  always @(negedge clk) begin
    cyc++;
    memRspValid = 0;
    if (pDue.size() > 0 && pDue[0] <= 32'(cyc)) begin
      logic [31:0] a;
      a = pAddr.pop_front();
      void'(pDue.pop_front());
      memRspTag   = pTag.pop_front();
      memRspData  = dataOf(a);
      memRspValid = 1;
    end
  end

  // request sampler and scoreboard monitor, just before the rising edge
  always begin
    @(negedge clk); #3;
    if (rstN && memReqValid && memReqReady) begin
      pAddr.push_back(memReqAddr);
      pTag.push_back(memReqTag);
      pDue.push_back(32'(cyc + LAT));
      reqCount++;
      if (!sawFirst) begin sawFirst = 1; firstReq = memReqAddr; end
    end
    if (rstN && !flushing && instValid && instReady) begin
      if (expQ.size() == 0) check(0, "R2 unexpected word", instAddr, 0);
      else begin
        logic [31:0] e;
        e = expQ.pop_front();
        check(instAddr == e, "R2 address order", instAddr, e);
        check(instData == dataOf(e), "R2/R9 word data", instData, dataOf(e));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finishRun();
  end

  task automatic stream(int n);
    @(negedge clk) instReady = 1;
    repeat (n) @(negedge clk);
    instReady = 0;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    logic [31:0] a;
    int rc;
    pushRun(RST_A);
    repeat (3) @(negedge clk);
    #3;
    check(instValid == 0, "R1 valid in reset", 32'(instValid), 0);
    check(ctrlRdData == 0, "R1 ctrl readback in reset", 32'(ctrlRdData), 0);
    @(negedge clk) rstN = 1;

    // R3: stalled core -> exactly DEPTH requests
    repeat (40) @(negedge clk);
    #3;
    check(firstReq == RST_A, "R1 first request", firstReq, RST_A);
    check(reqCount == 8, "R3 requests when full", 32'(reqCount), 8);
    check(instValid == 1, "R3 valid when full", 32'(instValid), 1);
    check(instAddr == RST_A, "R2 head address", instAddr, RST_A);
    @(negedge clk) instReady = 1;
    @(negedge clk) instReady = 0;
    repeat (20) @(negedge clk);
    #3;
    check(reqCount == 9, "R3 refill after one pop", 32'(reqCount), 9);
    stream(40);

    // R5: qualified store has no effect
    #3; a = instAddr; rc = reqCount;
    @(negedge clk) begin storeExec = 1; storeNoFlush = 1; end
    @(negedge clk) begin storeExec = 0; storeNoFlush = 0; end
    @(negedge clk); #3;
    check(instValid == 1, "R5 valid kept", 32'(instValid), 1);
    check(instAddr == a, "R5 head kept", instAddr, a);
    check(reqCount == rc, "R5 no refetch", 32'(reqCount), 32'(rc));

    // R4: plain store flushes, restart at next undelivered word
    @(negedge clk) storeExec = 1;
    @(negedge clk) begin storeExec = 0; pushRun(a); end
    #3;
    check(instValid == 0, "R4 valid after store flush", 32'(instValid), 0);
    check(memReqAddr == a, "R4 restart address", memReqAddr, a);
    stream(30);

    // R7: untaken transfer no effect, taken transfer flushes
    #3; a = instAddr;
    @(negedge clk) begin xferExec = 1; xferCondMet = 0; xferTarget = 32'h4000; end
    @(negedge clk) xferExec = 0;
    #3;
    check(instValid == 1 && instAddr == a, "R7 untaken no effect", instAddr, a);
    @(negedge clk) begin xferExec = 1; xferCondMet = 1; end
    @(negedge clk) begin xferExec = 0; xferCondMet = 0; pushRun(32'h4000); end
    #3;
    check(instValid == 0, "R7 valid after taken transfer", 32'(instValid), 0);
    check(memReqAddr == 32'h4000, "R7 restart at target", memReqAddr, 32'h4000);
    stream(30);

    // R8: control register flush bit
    #3; a = instAddr;
    @(negedge clk) begin ctrlWrite = 1; ctrlWData = 8'hBF; end
    @(negedge clk) ctrlWrite = 0;
    #3;
    check(ctrlRdData == 8'hBF, "R8 readback other bits", 32'(ctrlRdData), 32'hBF);
    check(instValid == 1 && instAddr == a, "R8 bit6 clear no flush", instAddr, a);
    @(negedge clk) begin ctrlWrite = 1; ctrlWData = 8'h40; end
    @(negedge clk) ctrlWrite = 0;
    #3;
    check(ctrlRdData == 8'h40, "R8 bit6 reads 1 one cycle", 32'(ctrlRdData), 32'h40);
    check(instValid == 1, "R8 flush not yet applied", 32'(instValid), 1);
    @(negedge clk) pushRun(a);
    #3;
    check(ctrlRdData == 8'h00, "R8 bit6 self-cleared", 32'(ctrlRdData), 0);
    check(instValid == 0, "R8 flush applied", 32'(instValid), 0);
    check(memReqAddr == a, "R8 restart address", memReqAddr, a);
    stream(30);

    // R6: pointer write
    @(negedge clk) begin ptrWrite = 1; ptrData = 32'h8000; end
    @(negedge clk) begin ptrWrite = 0; pushRun(32'h8000); end
    #3;
    check(instValid == 0, "R6 valid after pointer write", 32'(instValid), 0);
    check(memReqAddr == 32'h8000, "R6 restart at pointer", memReqAddr, 32'h8000);
    stream(30);

    // R11: simultaneous events, pointer write wins
    @(negedge clk) begin
      ptrWrite = 1; ptrData = 32'h1_0000;
      xferExec = 1; xferCondMet = 1; xferTarget = 32'h2_0000; storeExec = 1;
    end
    @(negedge clk) begin
      ptrWrite = 0; xferExec = 0; xferCondMet = 0; storeExec = 0;
      pushRun(32'h1_0000);
    end
    #3;
    check(memReqAddr == 32'h1_0000, "R11 pointer priority", memReqAddr, 32'h1_0000);
    @(negedge clk) instReady = 1;
    repeat (20) @(negedge clk);

    // R10: flush with a read in the same cycle
    @(negedge clk) begin flushing = 1; ptrWrite = 1; ptrData = 32'h2_4000; end
    #3;
    check(instValid == 1 && instReady == 1, "R10 read pending at flush", 32'(instValid), 1);
    @(negedge clk) begin ptrWrite = 0; pushRun(32'h2_4000); end
    #3;
    check(instValid == 0, "R10 valid low after flush", 32'(instValid), 0);
    flushing = 0;
    repeat (20) @(negedge clk);

    // R9: stale responses from a superseded pointer
    @(negedge clk) begin ptrWrite = 1; ptrData = 32'h3_0000; end
    @(negedge clk) ptrWrite = 0;
    repeat (2) @(negedge clk);
    @(negedge clk) begin ptrWrite = 1; ptrData = 32'h4_0000; end
    @(negedge clk) begin ptrWrite = 0; pushRun(32'h4_0000); end
    rc = vectors;
    repeat (40) @(negedge clk);
    #3;
    check(vectors - rc > 40, "R9 new stream delivered", 32'(vectors - rc), 41);
    check(instValid == 1 && instAddr[31:16] == 16'h0004, "R9 stream region", instAddr, 32'h4_0000);
    instReady = 0;
    finishRun();
  end
endmodule